// File: doc/BRIEF.md
# Configurable Sum-of-Products Array with Output Macrocells

This block is a small programmable logic array held in configuration flops. Three external inputs and the two macrocell feedback signals are offered to a programmable AND plane. Each signal appears there both true and inverted. Each of the eight product terms has one fuse bit per literal. The OR stage is hardwired: every output sums its own fixed group of four product terms.

Each sum drives an output macrocell. A macrocell holds a D flip-flop, a mode mux that selects either the combinational sum or the flip-flop, and an enable that decides whether the output is driven. The flip-flop output is routed back into the AND plane, so state machines can be built from the array.

The fuse map is shifted in serially before operation. The outputs stay undriven until a complete load has finished. An undriven output is modelled by a valid flag at 0, with the data pin held at 0.

Top module: `pal_array`

## Requirements
- R1: Configuration bits enter on `cfg_bit`, one per rising clock edge while `cfg_load` is high, least significant bit first. After the strobe falls, a burst of at least 84 bits makes the configuration active at the next rising edge. Fuse bit for product term T (0..7) and signal S is at index T*10+2*S for the true literal and T*10+2*S+1 for the complement. Signals 0..2 are `pal_in[0..2]` and signals 3..4 are the feedback of outputs 0 and 1. Bits 80+2*O and 81+2*O are the registered-mode bit and the enable bit of output O.
- R2: A product term is the AND of every literal whose fuse bit is 1.
- R3: A product term with no fuse bit set evaluates to 1.
- R4: A product term that connects both a signal and its complement evaluates to 0.
- R5: Output O is the OR of product terms 4*O to 4*O+3 and of no other term.
- R6: With the registered-mode bit at 0 the output follows the sum combinationally. With it at 1 the output shows the macrocell flip-flop.
- R7: The flip-flop captures the sum on each rising edge. It is 0 after a synchronous active-low reset and holds 0 while no configuration is active.
- R8: Feedback signal 3+O carries the flip-flop of output O, in both modes.
- R9: `pal_oe[O]` is 1 only when a configuration is active and the enable bit of output O is 1. `pal_out[O]` reads 0 whenever `pal_oe[O]` is 0.
- R10: After reset, during a load burst, and after a burst shorter than 84 bits, all outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Serial configuration strobe |
| cfg_bit | input | 1 | Serial configuration data, LSB first |
| pal_in | input | 3 | External logic inputs |
| pal_out | output | 2 | Macrocell outputs, 0 when not driven |
| pal_oe | output | 2 | Output driven flags |

## Verification
The bench loads maps that contain a contradictory term, an empty term, a toggle built from inverted feedback, and a registered output feeding a combinational one. A design that mishandled a literal/complement pair would let terms through and raise outputs that must stay low. A design that treated an empty term as 0 would leave a constant-1 output low. Wrong feedback routing or wrong mode selection would break the toggle sequence, or make the dependent output lead or lag by a cycle. Short bursts, mid-burst sampling and a reset pulse catch a design that drives its outputs before a full load is complete.

// File: rtl/pal_pkg.sv
// Shared sizing for the programmable array: inputs, outputs, terms per
// output and the derived fuse/configuration widths.
package pal_pkg;
    localparam int N_IN   = 3;
    localparam int N_OUT  = 2;
    localparam int N_PT   = 4;
    localparam int N_SIG  = N_IN + N_OUT;
    localparam int N_LIT  = 2 * N_SIG;
    localparam int N_TERM = N_OUT * N_PT;
    localparam int FUSE_W = N_TERM * N_LIT;
    localparam int MC_W   = 2;
    localparam int CFG_W  = FUSE_W + N_OUT * MC_W;
endpackage

// File: rtl/pal_cfg_loader.sv
// Serial configuration loader. Shifts cfg_bit in LSB first while
// cfg_load is high. Marks the configuration active once a burst of at
// least CFG_W bits has ended. Assumes the strobe is held for whole cycles.
module pal_cfg_loader #(
    parameter int CFG_W = pal_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    output logic [CFG_W-1:0] cfg_bits,
    output logic             cfg_done
);
    localparam int CNT_W = $clog2(CFG_W + 1);

    logic [CNT_W-1:0] bit_cnt;

    // Shift register holding the fuse map; not reset, like stored fuses.
    always_ff @(posedge clk) begin
        if (cfg_load) begin
            cfg_bits <= {cfg_bit, cfg_bits[CFG_W-1:1]};
        end
    end

    // Burst length counter and configuration-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cfg_done <= 1'b0;
        end else if (cfg_load) begin
            cfg_done <= 1'b0;
            if (bit_cnt != CNT_W'(CFG_W)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else begin
            bit_cnt <= '0;
            if (bit_cnt == CNT_W'(CFG_W)) begin
                cfg_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pal_and_plane.sv
// Programmable AND plane. Builds true and complement literals of every
// signal and forms each product term from the literals whose fuse is set.
// An unfused term is 1; a term holding a literal and its complement is 0.
module pal_and_plane #(
    parameter int N_SIG  = pal_pkg::N_SIG,
    parameter int N_TERM = pal_pkg::N_TERM
) (
    input  logic [N_SIG-1:0]            sig,
    input  logic [N_TERM*2*N_SIG-1:0]   fuses,
    output logic [N_TERM-1:0]           terms
);
    localparam int N_LIT = 2 * N_SIG;

    logic [N_LIT-1:0] lit;

    // Input buffers and inverters.
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[2*s]   = sig[s];
        assign lit[2*s+1] = ~sig[s];
    end

    // One wide AND per product term; unfused literals are forced to 1.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign terms[t] = &(~fuses[t*N_LIT +: N_LIT] | lit);
    end
endmodule

// File: rtl/pal_macrocell.sv
// Output macrocell: a D flip-flop on the sum, a mode mux choosing the
// sum or the flip-flop, and an enable. The flip-flop is cleared by reset
// and held at 0 while no configuration is active.
module pal_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic sum_in,
    input  logic reg_mode,
    input  logic out_en,
    output logic q,
    output logic pin,
    output logic pin_oe
);
    logic pin_val;

    // Registered path.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_done) begin
            q <= 1'b0;
        end else begin
            q <= sum_in;
        end
    end

    // Mode mux and output gating.
    always_comb begin
        pin_val = reg_mode ? q : sum_in;
        pin_oe  = cfg_done & out_en;
        pin     = pin_oe & pin_val;
    end
endmodule

// File: rtl/pal_array.sv
// Top of the programmable array: loader, AND plane, fixed OR groups and
// one macrocell per output. Feedback always comes from the macrocell
// flip-flops, so no combinational loop exists in either mode.
module pal_array #(
    parameter int N_IN  = pal_pkg::N_IN,
    parameter int N_OUT = pal_pkg::N_OUT,
    parameter int N_PT  = pal_pkg::N_PT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  pal_in,
    output logic [N_OUT-1:0] pal_out,
    output logic [N_OUT-1:0] pal_oe
);
    localparam int N_SIG  = N_IN + N_OUT;
    localparam int N_TERM = N_OUT * N_PT;
    localparam int FUSE_W = N_TERM * 2 * N_SIG;
    localparam int CFG_W  = FUSE_W + N_OUT * pal_pkg::MC_W;

    logic [CFG_W-1:0]  cfg_bits;
    logic              cfg_done;
    logic [N_TERM-1:0] terms;
    logic [N_OUT-1:0]  or_sum;
    logic [N_OUT-1:0]  fb_q;
    logic [N_OUT-1:0]  mc_reg;
    logic [N_OUT-1:0]  mc_en;

    pal_cfg_loader #(.CFG_W(CFG_W)) loader_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .cfg_bits (cfg_bits),
        .cfg_done (cfg_done)
    );

    pal_and_plane #(.N_SIG(N_SIG), .N_TERM(N_TERM)) plane_i (
        .sig   ({fb_q, pal_in}),
        .fuses (cfg_bits[FUSE_W-1:0]),
        .terms (terms)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Hardwired OR of this output's term group.
        assign or_sum[o] = |terms[o*N_PT +: N_PT];
        assign mc_reg[o] = cfg_bits[FUSE_W + 2*o];
        assign mc_en[o]  = cfg_bits[FUSE_W + 2*o + 1];

        pal_macrocell mc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_done (cfg_done),
            .sum_in   (or_sum[o]),
            .reg_mode (mc_reg[o]),
            .out_en   (mc_en[o]),
            .q        (fb_q[o]),
            .pin      (pal_out[o]),
            .pin_oe   (pal_oe[o])
        );
    end
endmodule

// File: rtl/pal_array_chk.sv
// Assertion checker for pal_array, attached by bind below.
module pal_array_chk #(
    parameter int N_OUT = pal_pkg::N_OUT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             cfg_done,
    input logic [N_OUT-1:0] pal_out,
    input logic [N_OUT-1:0] pal_oe,
    input logic [N_OUT-1:0] fb_q,
    input logic [N_OUT-1:0] or_sum,
    input logic [N_OUT-1:0] mc_reg
);
    AST_LOAD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (pal_oe == '0)); // R10

    AST_ACTIVE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(!cfg_load)); // R1

    AST_FF_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (fb_q == '0)); // R7

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !pal_oe[o] |-> !pal_out[o]); // R9

        AST_REG_MODE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            (pal_oe[o] && mc_reg[o] && $past(cfg_done) && $past(!cfg_load))
                |-> (pal_out[o] == $past(or_sum[o]))); // R6
    end
endmodule

bind pal_array pal_array_chk #(.N_OUT(N_OUT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_done (cfg_done),
    .pal_out  (pal_out),
    .pal_oe   (pal_oe),
    .fb_q     (fb_q),
    .or_sum   (or_sum),
    .mc_reg   (mc_reg)
);

// File: tb/pal_array_tb_top.sv
`timescale 1ns/1ps
module pal_array_tb_top;
    localparam int CW = 84;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [2:0] pal_in = '0;
    logic [1:0] pal_out;
    logic [1:0] pal_oe;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state kept by the bench.
    logic [CW-1:0] cfg_m = '0;
    logic [CW-1:0] cfg_w;
    logic          done_m = 1'b0;
    logic [1:0]    mq = '0;

    always #2 clk = ~clk;

    pal_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .pal_in(pal_in), .pal_out(pal_out), .pal_oe(pal_oe)
    );

    function automatic logic ref_term(int t, logic [2:0] x, logic [1:0] q);
        logic [4:0] s = {q, x};
        for (int i = 0; i < 5; i++) begin
            if (cfg_m[t*10 + 2*i] && !s[i]) return 1'b0;
            if (cfg_m[t*10 + 2*i + 1] && s[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic ref_sum(int o, logic [2:0] x, logic [1:0] q);
        logic r = 1'b0;
        for (int t = 0; t < 4; t++) r |= ref_term(o*4 + t, x, q);
        return r;
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Apply one input pattern, compare both outputs, then clock once.
    task automatic step(logic [2:0] x, string tag);
        logic [1:0] nq;
        @(negedge clk);
        pal_in = x;
        #1;
        for (int o = 0; o < 2; o++) begin
            logic eo, ev;
            eo = done_m & cfg_m[81 + 2*o];
            ev = eo & (cfg_m[80 + 2*o] ? mq[o] : ref_sum(o, x, mq));
            check(tag, $sformatf("oe[%0d]", o), pal_oe[o], eo);
            check(tag, $sformatf("out[%0d]", o), pal_out[o], ev);
        end
        for (int o = 0; o < 2; o++) nq[o] = done_m & ref_sum(o, x, mq);
        @(posedge clk);
        mq = nq;
    endtask

    task automatic lit(int o, int t, int s, int comp);
        cfg_w[(o*4 + t)*10 + 2*s + comp] = 1'b1;
    endtask

    task automatic mc(int o, logic regm, logic en);
        cfg_w[80 + 2*o] = regm;
        cfg_w[81 + 2*o] = en;
    endtask

    // Serial load of nbits; checks outputs are off mid-burst (R10).
    task automatic load(int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_bit = cfg_w[i];
            if (i == 10) begin
                #1;
                check("R10", "oe during load", pal_oe[0] | pal_oe[1], 1'b0);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        @(posedge clk);
        if (nbits >= CW) begin
            cfg_m = cfg_w;
            done_m = 1'b1;
        end else begin
            done_m = 1'b0;
        end
        mq = '0;
    endtask

    task automatic t_reset_state();
        step(3'b101, "R10 reset");
        step(3'b010, "R10 reset");
    endtask

    // out0 = x0&~x1 | x1&x2 combinational (R2,R4,R5); out1 toggles via ~fb1 (R6,R7,R8).
    task automatic t_comb_and_toggle();
        cfg_w = '0;
        lit(0, 0, 0, 0); lit(0, 0, 1, 1);
        lit(0, 1, 2, 0); lit(0, 1, 1, 0);
        lit(0, 2, 0, 0); lit(0, 2, 0, 1);
        lit(0, 3, 2, 0); lit(0, 3, 2, 1);
        mc(0, 1'b0, 1'b1);
        lit(1, 0, 4, 1);
        for (int t = 1; t < 4; t++) begin lit(1, t, 1, 0); lit(1, t, 1, 1); end
        mc(1, 1'b1, 1'b1);
        load(CW);
        for (int v = 0; v < 8; v++) step(3'(v), "R1 R2 R4 R5 R6 R8");
    endtask

    // out0 registered D of x0; out1 comb = fb0 & x1 (R8, R6, R7).
    task automatic t_feedback_chain();
        cfg_w = '0;
        lit(0, 0, 0, 0);
        for (int t = 1; t < 4; t++) begin lit(0, t, 0, 0); lit(0, t, 0, 1); end
        mc(0, 1'b1, 1'b1);
        lit(1, 0, 3, 0); lit(1, 0, 1, 0);
        for (int t = 1; t < 4; t++) begin lit(1, t, 2, 0); lit(1, t, 2, 1); end
        mc(1, 1'b0, 1'b1);
        load(CW);
        step(3'b011, "R7 R8");
        step(3'b010, "R7 R8");
        step(3'b011, "R7 R8");
        step(3'b001, "R7 R8");
        step(3'b110, "R6 R8");
    endtask

    // out0 empty term -> constant 1 (R3); out1 disabled by enable bit (R9).
    task automatic t_empty_and_disable();
        cfg_w = '0;
        for (int t = 1; t < 4; t++) lit(0, t, 1, 0);
        mc(0, 1'b0, 1'b1);
        lit(1, 0, 0, 0);
        mc(1, 1'b0, 1'b0);
        load(CW);
        step(3'b000, "R3 R9");
        step(3'b111, "R3 R9");
        step(3'b001, "R3 R9");
    endtask

    // Short burst leaves outputs disabled (R10, R1).
    task automatic t_short_load();
        load(40);
        step(3'b111, "R10 short");
        step(3'b000, "R10 short");
    endtask

    // Reset disables outputs and clears the flip-flops (R7, R10).
    task automatic t_reset_pulse();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        done_m = 1'b0;
        mq = '0;
        step(3'b001, "R7 R10");
        load(CW);
        step(3'b001, "R7");
        step(3'b000, "R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_comb_and_toggle();
        t_feedback_chain();
        t_empty_and_disable();
        t_short_load();
        t_comb_and_toggle();
        t_reset_pulse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule